// File: doc/BRIEF.md
# Backplane Window and Segment Mapper

This block connects a narrow host memory window to a 32-bit internal backplane. Software picks which 4 KB core slot is visible by writing a window base into three byte-wide configuration registers. For a core with index `n`, the base is the enumeration base plus `n` times the 4 KB slot size. A one-bit segment register records which 2 KB half of that slot is mapped. Every register can be read back, so software can confirm that a switch took effect.

Host accesses carry a 12-bit offset and a byte, halfword or word size. Offset bit 11 picks the segment, and the segment register follows each accepted access. The block builds the full backplane address from the base, the segment bit and the low 11 offset bits. A word access is carried out as two halfword beats on the backplane. When the backplane reports an error, a read returns all ones at the width that was asked for.

Top module: `bp_window_mapper`

## Requirements
- R1: After reset the window base and the segment register are zero, `bp_req_o` is low and `host_ready_o` is high.
- R2: Configuration offset 0x2E holds base bits 15..12 in its low nibble and reads back with the upper nibble zero. Offset 0x30 holds bits 23..16 and offset 0x32 holds bits 31..24. A read returns the last value written, combinationally from `cfg_addr_i`, and unmapped offsets read 0.
- R3: Configuration offset 0x34 is the segment register. A write of 0 or 1 stores that value, a write of any other value leaves it unchanged, and a read returns the current segment in bit 0.
- R4: The backplane address is base bits 31..12, then host offset bit 11 as the segment bit, then host offset bits 10..0. An offset at or above 0x800 is therefore segment 1 at offset minus 0x800.
- R5: Every accepted host access loads its segment (offset bit 11) into the segment register, and a read at 0x34 shows it. This takes priority over a configuration write in the same cycle.
- R6: `host_size_i` is coded as 0 for byte, 1 for halfword, and 2 or 3 for word. A byte or halfword access is one beat, with `bp_size_o` equal to that code. A word access is two halfword beats (`bp_size_o`=1): the low half at the offset first, then the high half at the offset plus 2, with the low 11 bits wrapping inside the 2 KB half.
- R7: Write data on a beat is `host_wdata_i[15:0]` for a halfword and for the first word beat, `host_wdata_i[31:16]` for the second word beat, and `{8'h00, host_wdata_i[7:0]}` for a byte.
- R8: Read data is `bp_rdata_i[7:0]` zero-extended for a byte, `bp_rdata_i` zero-extended for a halfword, and `{second beat, first beat}` for a word. A write returns 0.
- R9: If any beat of a read gets `bp_err_i`, the read returns 0xFF for a byte, 0xFFFF for a halfword and 0xFFFFFFFF for a word.
- R10: A request is accepted when `host_req_i` and `host_ready_o` are both high at a clock edge. `bp_req_o` rises in the next cycle and holds its address, size, direction and data until `bp_ack_i`. `host_done_o` pulses one cycle after the final acknowledge, with `host_rdata_o` valid. `host_ready_o` is low for the whole access.
- R11: The base and segment are captured when an access is accepted. Configuration writes during the access do not change its beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration register offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for `cfg_addr_i` |
| host_req_i | input | 1 | Host access request |
| host_ready_o | output | 1 | Block idle, request can be accepted |
| host_we_i | input | 1 | Host access is a write |
| host_size_i | input | 2 | Access size code |
| host_off_i | input | 12 | Offset within the host window |
| host_wdata_i | input | 32 | Host write data |
| host_done_o | output | 1 | Access complete pulse |
| host_rdata_o | output | 32 | Host read data |
| bp_req_o | output | 1 | Backplane beat request |
| bp_we_o | output | 1 | Beat is a write |
| bp_size_o | output | 2 | Beat size code (0 byte, 1 halfword) |
| bp_addr_o | output | 32 | Beat byte address |
| bp_wdata_o | output | 16 | Beat write data |
| bp_ack_i | input | 1 | Beat acknowledge |
| bp_err_i | input | 1 | Beat error, valid with the acknowledge |
| bp_rdata_i | input | 16 | Beat read data, valid with the acknowledge |

## Verification
Register readback is combinational, so the bench samples `cfg_rdata_o` in the same cycle it sets the offset. A configuration write is sampled only after the clock edge that stores it. The first beat appears in the cycle after the accepting edge. A second word beat follows the cycle after the first acknowledge. The bench's backplane model notes the cycle in which it raises each acknowledge. Every access then checks that `host_done_o` is seen exactly one cycle later. The beat address, size and data are recorded at the moment of the acknowledge and compared with values computed from R4, R6 and R7. Acknowledge latency is varied so that the hold behaviour is exercised.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WORD_ALT = 2'd3
  } acc_size_e;

  localparam logic [7:0] CFG_WIN_LO  = 8'h2E;
  localparam logic [7:0] CFG_WIN_MID = 8'h30;
  localparam logic [7:0] CFG_WIN_HI  = 8'h32;
  localparam logic [7:0] CFG_SEG     = 8'h34;

  localparam int WIN_LO_W = 4;
  localparam int WIN_BYTE_W = 8;
endpackage

// File: rtl/bpw_cfg_regs.sv
module bpw_cfg_regs
  import bpw_pkg::*;
#(
  parameter int BASE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              seg_load_i,
  input  logic              seg_val_i,
  output logic [7:0]        cfg_rdata_o,
  output logic [BASE_W-1:0] base_o,
  output logic              seg_o
);
  logic [WIN_LO_W-1:0]   win_lo_q;
  logic [WIN_BYTE_W-1:0] win_mid_q, win_hi_q;
  logic                  seg_q;
  logic                  seg_wr_ok;

  assign seg_wr_ok = cfg_we_i && (cfg_addr_i == CFG_SEG) && (cfg_wdata_i[7:1] == 7'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_lo_q  <= '0;
      win_mid_q <= '0;
      win_hi_q  <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        CFG_WIN_LO:  win_lo_q  <= cfg_wdata_i[WIN_LO_W-1:0];
        CFG_WIN_MID: win_mid_q <= cfg_wdata_i;
        CFG_WIN_HI:  win_hi_q  <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  // access-driven segment load wins over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         seg_q <= 1'b0;
    else if (seg_load_i) seg_q <= seg_val_i;
    else if (seg_wr_ok)  seg_q <= cfg_wdata_i[0];
  end

  always_comb begin
    case (cfg_addr_i)
      CFG_WIN_LO:  cfg_rdata_o = 8'(win_lo_q);
      CFG_WIN_MID: cfg_rdata_o = win_mid_q;
      CFG_WIN_HI:  cfg_rdata_o = win_hi_q;
      CFG_SEG:     cfg_rdata_o = {7'd0, seg_q};
      default:     cfg_rdata_o = 8'd0;
    endcase
  end

  assign base_o = BASE_W'({win_hi_q, win_mid_q, win_lo_q});
  assign seg_o  = seg_q;

  p_seg_illegal_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == CFG_SEG && cfg_wdata_i > 8'd1 && !seg_load_i)
      |=> seg_q == $past(seg_q));

  p_win_mid_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == CFG_WIN_MID) |=> cfg_addr_i != CFG_WIN_MID
      || cfg_rdata_o == $past(cfg_wdata_i));
endmodule

// File: rtl/bpw_beat_seq.sv
module bpw_beat_seq
  import bpw_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int BEAT_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-OFF_W-1:0] base_i,
  input  logic                    host_req_i,
  output logic                    host_ready_o,
  input  logic                    host_we_i,
  input  logic [1:0]              host_size_i,
  input  logic [OFF_W-1:0]        host_off_i,
  input  logic [2*BEAT_W-1:0]     host_wdata_i,
  output logic                    host_done_o,
  output logic [2*BEAT_W-1:0]     host_rdata_o,
  output logic                    seg_load_o,
  output logic                    seg_val_o,
  output logic                    bp_req_o,
  output logic                    bp_we_o,
  output logic [1:0]              bp_size_o,
  output logic [ADDR_W-1:0]       bp_addr_o,
  output logic [BEAT_W-1:0]       bp_wdata_o,
  input  logic                    bp_ack_i,
  input  logic                    bp_err_i,
  input  logic [BEAT_W-1:0]       bp_rdata_i
);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int LOW_W  = OFF_W - 1;
  localparam int DATA_W = 2 * BEAT_W;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} state_e;

  state_e              state_q;
  acc_size_e           size_q;
  logic                we_q, seg_q, err_q, done_q;
  logic [BASE_W-1:0]   base_q;
  logic [LOW_W-1:0]    off_q, off_beat;
  logic [DATA_W-1:0]   wdata_q, rdata_q, rd_next;
  logic [BEAT_W-1:0]   lo_q;
  logic                word_q, accept;

  assign word_q       = size_q[1];
  assign host_ready_o = (state_q == S_IDLE);
  assign accept       = host_req_i && host_ready_o;
  assign seg_load_o   = accept;
  assign seg_val_o    = host_off_i[OFF_W-1];

  always_comb begin
    if (we_q) rd_next = '0;
    else begin
      case (size_q)
        SZ_BYTE: rd_next = bp_err_i ? DATA_W'(8'hFF) : DATA_W'(bp_rdata_i[7:0]);
        SZ_HALF: rd_next = bp_err_i ? DATA_W'({BEAT_W{1'b1}}) : DATA_W'(bp_rdata_i);
        default: rd_next = (err_q || bp_err_i) ? '1 : {bp_rdata_i, lo_q};
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      size_q  <= SZ_BYTE;
      we_q    <= 1'b0;
      seg_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      base_q  <= '0;
      off_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      lo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (host_req_i) begin
          size_q  <= acc_size_e'(host_size_i);
          we_q    <= host_we_i;
          seg_q   <= host_off_i[OFF_W-1];
          base_q  <= base_i;
          off_q   <= host_off_i[LOW_W-1:0];
          wdata_q <= host_wdata_i;
          err_q   <= 1'b0;
          state_q <= S_LO;
        end
        S_LO: if (bp_ack_i) begin
          if (word_q) begin
            lo_q    <= bp_rdata_i;
            err_q   <= bp_err_i;
            state_q <= S_HI;
          end else begin
            done_q  <= 1'b1;
            rdata_q <= rd_next;
            state_q <= S_IDLE;
          end
        end
        S_HI: if (bp_ack_i) begin
          done_q  <= 1'b1;
          rdata_q <= rd_next;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign off_beat     = (state_q == S_HI) ? off_q + LOW_W'(2) : off_q;
  assign bp_req_o     = (state_q != S_IDLE);
  assign bp_we_o      = we_q;
  assign bp_size_o    = word_q ? SZ_HALF : size_q;
  assign bp_addr_o    = {base_q, seg_q, off_beat};
  assign bp_wdata_o   = (state_q == S_HI)  ? wdata_q[DATA_W-1:BEAT_W] :
                        (size_q == SZ_BYTE) ? BEAT_W'(wdata_q[7:0]) : wdata_q[BEAT_W-1:0];
  assign host_done_o  = done_q;
  assign host_rdata_o = rdata_q;

  p_beat_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_req_o && !bp_ack_i) |=> bp_req_o && $stable(bp_addr_o) && $stable(bp_we_o)
      && $stable(bp_wdata_o) && $stable(bp_size_o));

  p_hi_beat_plus2_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LO && bp_ack_i && word_q) |=> bp_req_o
      && bp_addr_o[LOW_W-1:0] == LOW_W'($past(bp_addr_o[LOW_W-1:0]) + LOW_W'(2))
      && bp_addr_o[ADDR_W-1:LOW_W] == $past(bp_addr_o[ADDR_W-1:LOW_W]));

  p_done_after_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |-> $past(bp_ack_i) && host_ready_o);

  p_busy_not_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_req_o |-> !host_ready_o);
endmodule

// File: rtl/bp_window_mapper.sv
module bp_window_mapper
  import bpw_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int BEAT_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [7:0]          cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  input  logic                host_req_i,
  output logic                host_ready_o,
  input  logic                host_we_i,
  input  logic [1:0]          host_size_i,
  input  logic [OFF_W-1:0]    host_off_i,
  input  logic [2*BEAT_W-1:0] host_wdata_i,
  output logic                host_done_o,
  output logic [2*BEAT_W-1:0] host_rdata_o,
  output logic                bp_req_o,
  output logic                bp_we_o,
  output logic [1:0]          bp_size_o,
  output logic [ADDR_W-1:0]   bp_addr_o,
  output logic [BEAT_W-1:0]   bp_wdata_o,
  input  logic                bp_ack_i,
  input  logic                bp_err_i,
  input  logic [BEAT_W-1:0]   bp_rdata_i
);
  localparam int BASE_W = ADDR_W - OFF_W;

  logic [BASE_W-1:0] base;
  logic              seg, seg_load, seg_val;

  bpw_cfg_regs #(.BASE_W(BASE_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .seg_load_i  (seg_load),
    .seg_val_i   (seg_val),
    .cfg_rdata_o (cfg_rdata_o),
    .base_o      (base),
    .seg_o       (seg)
  );

  bpw_beat_seq #(.OFF_W(OFF_W), .BEAT_W(BEAT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_i       (base),
    .host_req_i   (host_req_i),
    .host_ready_o (host_ready_o),
    .host_we_i    (host_we_i),
    .host_size_i  (host_size_i),
    .host_off_i   (host_off_i),
    .host_wdata_i (host_wdata_i),
    .host_done_o  (host_done_o),
    .host_rdata_o (host_rdata_o),
    .seg_load_o   (seg_load),
    .seg_val_o    (seg_val),
    .bp_req_o     (bp_req_o),
    .bp_we_o      (bp_we_o),
    .bp_size_o    (bp_size_o),
    .bp_addr_o    (bp_addr_o),
    .bp_wdata_o   (bp_wdata_o),
    .bp_ack_i     (bp_ack_i),
    .bp_err_i     (bp_err_i),
    .bp_rdata_i   (bp_rdata_i)
  );

  p_seg_follows_access_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_ready_o) |=> seg == $past(host_off_i[OFF_W-1]));

  p_addr_seg_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && host_ready_o) |=> bp_addr_o[OFF_W-1] == $past(host_off_i[OFF_W-1]));
endmodule

// File: tb/bp_window_mapper_tb.sv
module bp_window_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'd0, cfg_wdata = 8'd0, cfg_rdata;
  logic        host_req = 1'b0, host_we = 1'b0, host_ready, host_done;
  logic [1:0]  host_size = 2'd0;
  logic [11:0] host_off = 12'd0;
  logic [31:0] host_wdata = 32'd0, host_rdata;
  logic        bp_req, bp_we;
  logic [1:0]  bp_size;
  logic [31:0] bp_addr;
  logic [15:0] bp_wdata;
  logic        bp_ack = 1'b0, bp_err = 1'b0;
  logic [15:0] bp_rdata = 16'd0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, ack_cyc = 0, lat = 0, wait_cnt = 0, nbeats = 0;
  bit err_mode = 1'b0;
  logic [31:0] b_addr[4];
  logic [15:0] b_wd[4];
  logic [1:0]  b_sz[4];
  logic [31:0] base_val;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bp_window_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .host_req_i(host_req), .host_ready_o(host_ready), .host_we_i(host_we),
    .host_size_i(host_size), .host_off_i(host_off), .host_wdata_i(host_wdata),
    .host_done_o(host_done), .host_rdata_o(host_rdata),
    .bp_req_o(bp_req), .bp_we_o(bp_we), .bp_size_o(bp_size), .bp_addr_o(bp_addr),
    .bp_wdata_o(bp_wdata), .bp_ack_i(bp_ack), .bp_err_i(bp_err), .bp_rdata_i(bp_rdata)
  );

  function automatic logic [15:0] mdata(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [11:0] off, input int k);
    logic [10:0] lo;
    lo = off[10:0] + 11'(2 * k);
    return {b[31:12], off[11], lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // backplane model
  initial begin
    forever begin
      @(negedge clk);
      if (bp_ack) begin bp_ack = 1'b0; bp_err = 1'b0; end
      if (bp_req && !bp_ack) begin
        if (wait_cnt >= lat) begin
          bp_ack = 1'b1;
          bp_err = err_mode;
          bp_rdata = mdata(bp_addr);
          if (nbeats < 4) begin
            b_addr[nbeats] = bp_addr; b_wd[nbeats] = bp_wdata; b_sz[nbeats] = bp_size;
          end
          nbeats++;
          ack_cyc = cyc;
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_core(input int idx);
    base_val = 32'h1800_0000 + idx * 32'h1000;
    cfg_write(8'h2E, base_val[19:12]);
    cfg_write(8'h30, base_val[23:16]);
    cfg_write(8'h32, base_val[31:24]);
  endtask

  task automatic start(input logic we, input logic [1:0] sz, input logic [11:0] off, input logic [31:0] wd);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    nbeats = 0;
    host_req = 1'b1; host_we = we; host_size = sz; host_off = off; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic finish(output logic [31:0] rd);
    int guard = 0;
    while (!host_done && guard < 50) begin @(negedge clk); guard++; end
    chk("R10 done one cycle after ack", 32'(cyc), 32'(ack_cyc + 1));
    rd = host_rdata;
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [11:0] off,
                        input logic [31:0] wd, output logic [31:0] rd);
    start(we, sz, off, wd);
    finish(rd);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 ready after reset", 32'(host_ready), 32'd1);
    chk("R1 no request after reset", 32'(bp_req), 32'd0);
    cfg_read(8'h2E, d); chk("R1 base lo zero", 32'(d), 32'd0);
    cfg_read(8'h30, d); chk("R1 base mid zero", 32'(d), 32'd0);
    cfg_read(8'h32, d); chk("R1 base hi zero", 32'(d), 32'd0);
    cfg_read(8'h34, d); chk("R1 segment zero", 32'(d), 32'd0);
  endtask

  task automatic t_window_regs();
    logic [7:0] d;
    cfg_write(8'h2E, 8'hAB); cfg_read(8'h2E, d); chk("R2 low nibble only", 32'(d), 32'h0B);
    cfg_write(8'h30, 8'hC4); cfg_read(8'h30, d); chk("R2 mid readback", 32'(d), 32'hC4);
    cfg_write(8'h32, 8'h7E); cfg_read(8'h32, d); chk("R2 hi readback", 32'(d), 32'h7E);
    cfg_write(8'h40, 8'h55); cfg_read(8'h40, d); chk("R2 unmapped reads 0", 32'(d), 32'h00);
  endtask

  task automatic t_segment_reg();
    logic [7:0] d;
    cfg_write(8'h34, 8'h01); cfg_read(8'h34, d); chk("R3 seg set 1", 32'(d), 32'd1);
    cfg_write(8'h34, 8'h05); cfg_read(8'h34, d); chk("R3 illegal value ignored", 32'(d), 32'd1);
    cfg_write(8'h34, 8'h00); cfg_read(8'h34, d); chk("R3 seg set 0", 32'(d), 32'd0);
  endtask

  task automatic t_half_read();
    logic [31:0] rd;
    logic [7:0] d;
    set_core(3);
    lat = 0; err_mode = 0;
    access(1'b0, 2'd1, 12'h124, 32'd0, rd);
    chk("R4 half addr", b_addr[0], exp_addr(base_val, 12'h124, 0));
    chk("R4 core slot base", b_addr[0], 32'h1800_3124);
    chk("R6 half size", 32'(b_sz[0]), 32'd1);
    chk("R6 single beat", 32'(nbeats), 32'd1);
    chk("R8 half data", rd, {16'd0, mdata(b_addr[0])});
    access(1'b0, 2'd1, 12'h9A0, 32'd0, rd);
    chk("R4 upper segment addr", b_addr[0], exp_addr(base_val, 12'h9A0, 0));
    cfg_read(8'h34, d); chk("R5 seg follows access", 32'(d), 32'd1);
    access(1'b0, 2'd1, 12'h010, 32'd0, rd);
    cfg_read(8'h34, d); chk("R5 seg back to 0", 32'(d), 32'd0);
  endtask

  task automatic t_word_write();
    logic [31:0] rd;
    lat = 2;
    access(1'b1, 2'd2, 12'h010, 32'hDEAD_BEEF, rd);
    chk("R6 two beats", 32'(nbeats), 32'd2);
    chk("R6 low beat first", b_addr[0], exp_addr(base_val, 12'h010, 0));
    chk("R6 high beat +2", b_addr[1], exp_addr(base_val, 12'h010, 1));
    chk("R6 beat size half", 32'(b_sz[1]), 32'd1);
    chk("R7 low data", 32'(b_wd[0]), 32'hBEEF);
    chk("R7 high data", 32'(b_wd[1]), 32'hDEAD);
    chk("R8 write returns 0", rd, 32'd0);
  endtask

  task automatic t_word_read_wrap();
    logic [31:0] rd;
    lat = 1;
    access(1'b0, 2'd3, 12'h7FE, 32'd0, rd);
    chk("R6 wrap first", b_addr[0], exp_addr(base_val, 12'h7FE, 0));
    chk("R6 wrap inside half", b_addr[1], {base_val[31:12], 12'h000});
    chk("R8 word combine", rd, {mdata(b_addr[1]), mdata(b_addr[0])});
  endtask

  task automatic t_byte();
    logic [31:0] rd;
    lat = 0;
    access(1'b1, 2'd0, 12'h033, 32'h1234_56A7, rd);
    chk("R6 byte size", 32'(b_sz[0]), 32'd0);
    chk("R7 byte data low lane", 32'(b_wd[0]), 32'h00A7);
    access(1'b0, 2'd0, 12'h033, 32'd0, rd);
    chk("R8 byte zero-extended", rd, {24'd0, mdata(b_addr[0]) & 16'h00FF});
  endtask

  task automatic t_errors();
    logic [31:0] rd;
    err_mode = 1; lat = 0;
    access(1'b0, 2'd0, 12'h100, 32'd0, rd); chk("R9 byte error", rd, 32'h0000_00FF);
    access(1'b0, 2'd1, 12'h100, 32'd0, rd); chk("R9 half error", rd, 32'h0000_FFFF);
    access(1'b0, 2'd2, 12'h100, 32'd0, rd); chk("R9 word error", rd, 32'hFFFF_FFFF);
    err_mode = 0;
  endtask

  task automatic t_snapshot();
    logic [31:0] rd;
    logic [31:0] old_base;
    logic [7:0] d;
    old_base = base_val;
    lat = 4;
    start(1'b0, 2'd2, 12'h840, 32'd0);
    chk("R10 busy not ready", 32'(host_ready), 32'd0);
    chk("R10 request raised", 32'(bp_req), 32'd1);
    cfg_write(8'h30, 8'hEE);
    cfg_write(8'h34, 8'h00);
    finish(rd);
    chk("R11 lo beat uses captured base", b_addr[0], exp_addr(old_base, 12'h840, 0));
    chk("R11 hi beat uses captured base", b_addr[1], exp_addr(old_base, 12'h840, 1));
    cfg_read(8'h30, d); chk("R2 write during access stored", 32'(d), 32'hEE);
    cfg_read(8'h34, d); chk("R3 seg write during access", 32'(d), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window_regs();
    t_segment_reg();
    t_half_read();
    t_word_write();
    t_word_read_wrap();
    t_byte();
    t_errors();
    t_snapshot();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule